// File: doc/BRIEF.md
# Serial Display-Memory Write Parser

This block receives a serial byte stream from a host through a three-wire slave port. The wires are an active-low select, a shift clock and a data line. It turns the stream into single-cycle write requests for an on-screen-display memory. That memory is addressed by a row number (0 to 10) and a column number (0 to 31). Rows 0 to 9 hold character codes in columns 0 to 23 and per-row control in columns 30 and 31. Row 10 holds the window and frame control registers in columns 0 to 12. The memory and the display refresh logic sit outside the block. The block only produces the write strobe, the row, the column and the data.

The three wire inputs are brought into the system clock domain through a synchroniser chain. The data line is sampled on each rising edge of the shift clock, eight bits to a byte, most significant bit first.

The parser sorts every byte into one of three kinds: a row address, a column address or data. Three stream formats are supported:
- row, column, data, repeated;
- one row, then column and data pairs;
- a continuous format, in which one column byte switches every later byte of the transfer to data at an address that advances by itself.

The host may mix the first two formats freely. Entry into the continuous format cannot be undone until the select line is released.

Top module: `spi_ram_writer`

## Requirements
- R1: After reset, wr_en is 0 and wr_row, wr_col and wr_data are all 0.
- R2: Each byte is assembled from eight MOSI samples taken on rising SCK edges while ss_n is low, first sample as bit 7; a data byte appears unchanged on wr_data.
- R3: When an address is expected, a byte with bit 7 = 1 sets the row from its bits 3:0; a byte with bit 7 = 0 sets the column from its bits 4:0; bits 6:4 of a row byte and bit 5 of a column byte are ignored.
- R4: In a row, column, data sequence, the data byte produces exactly one write at that row and column.
- R5: After a data byte, the parser expects an address again; a column byte followed by data writes at the row held from before, and a new row byte may follow instead.
- R6: A column byte with bit 6 = 1 enters continuous mode: every later byte in the transfer is written, the first at the given column, each next one at the column plus one.
- R7: In continuous mode, a write at column 31 is followed by the next write at column 0 of the next row.
- R8: Once in continuous mode, a byte with bit 7 = 1 is still written as data and does not change the row.
- R9: Raising ss_n returns the parser to expecting an address and discards a partly received byte.
- R10: SCK activity while ss_n is high produces no write.
- R11: Each data byte yields one wr_en pulse exactly one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ss_n | input | 1 | Slave select, active low, asynchronous |
| sck | input | 1 | Serial shift clock, asynchronous |
| mosi | input | 1 | Serial data in, asynchronous |
| wr_en | output | 1 | One-cycle memory write strobe |
| wr_row | output | ROW_W (4) | Row address of the write |
| wr_col | output | COL_W (5) | Column address of the write |
| wr_data | output | DATA_W (8) | Byte to be written |

## Verification
An error in the bit counter or the byte assembly shows as rotated data on wr_data at the next data byte. A wrong parse mode shows as a missing write, an extra write, or a write at the wrong address. These errors appear within a byte time of the bad decision, and they keep appearing for the rest of the transfer.

A faulty continuous-mode address counter shows at the first write after column 31. Select-release handling is visible at the first byte of the following transfer. A bad partial-byte reset or a mode that persists across transfers misaligns that whole transfer.

// File: rtl/spi_wr_pkg.sv
package spi_wr_pkg;
   typedef enum logic [1:0] {
      PM_ADDR   = 2'd0,
      PM_DATA   = 2'd1,
      PM_STREAM = 2'd2
   } parse_mode_e;

   localparam int HDR_ROW_BIT    = 7;
   localparam int HDR_STREAM_BIT = 6;
endpackage

// File: rtl/spi_wr_sync.sv
module spi_wr_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] d_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_wr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= RST_VAL;
      else        stg[0] <= d_async;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
         end
      end
   endgenerate

   assign d_sync = stg[STAGES-1];
endmodule

// File: rtl/spi_wr_shifter.sv
module spi_wr_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ss_hi,
   input  logic              sck_s,
   input  logic              mosi_s,
   output logic              byte_vld,
   output logic [DATA_W-1:0] byte_q
);
   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

   logic             sck_q;
   logic [CNT_W-1:0] bit_cnt;
   logic             sck_rise;

   assign sck_rise = sck_s & ~sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q    <= 1'b0;
         bit_cnt  <= '0;
         byte_vld <= 1'b0;
         byte_q   <= '0;
      end else begin
         sck_q    <= sck_s;
         byte_vld <= 1'b0;
         if (ss_hi) begin
            bit_cnt <= '0;
         end else if (sck_rise) begin
            byte_q <= {byte_q[DATA_W-2:0], mosi_s};
            if (bit_cnt == CNT_LAST) begin
               bit_cnt  <= '0;
               byte_vld <= 1'b1;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

   // R9 / R10: a released select clears the bit position and yields no byte
   p_release_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ss_hi |=> (bit_cnt == '0) && !byte_vld);

   // R2: a byte completes only on a shift-clock edge
   p_byte_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |-> $past(sck_s) && !$past(sck_q));
endmodule

// File: rtl/spi_wr_parser.sv
module spi_wr_parser
   import spi_wr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ROW_W  = 4,
   parameter int COL_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ss_hi,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_q,
   output logic              wr_en,
   output logic [ROW_W-1:0]  wr_row,
   output logic [COL_W-1:0]  wr_col,
   output logic [DATA_W-1:0] wr_data
);
   localparam logic [COL_W-1:0] COL_LAST = '1;

   parse_mode_e      mode;
   logic [ROW_W-1:0] cur_row;
   logic [COL_W-1:0] cur_col;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode    <= PM_ADDR;
         cur_row <= '0;
         cur_col <= '0;
         wr_en   <= 1'b0;
         wr_row  <= '0;
         wr_col  <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (byte_vld) begin
            unique case (mode)
               PM_ADDR: begin
                  if (byte_q[HDR_ROW_BIT]) begin
                     cur_row <= byte_q[ROW_W-1:0];
                  end else begin
                     cur_col <= byte_q[COL_W-1:0];
                     mode    <= byte_q[HDR_STREAM_BIT] ? PM_STREAM : PM_DATA;
                  end
               end
               PM_DATA: begin
                  wr_en   <= 1'b1;
                  wr_row  <= cur_row;
                  wr_col  <= cur_col;
                  wr_data <= byte_q;
                  mode    <= PM_ADDR;
               end
               PM_STREAM: begin
                  wr_en   <= 1'b1;
                  wr_row  <= cur_row;
                  wr_col  <= cur_col;
                  wr_data <= byte_q;
                  cur_col <= cur_col + 1'b1;
                  if (cur_col == COL_LAST) cur_row <= cur_row + 1'b1;
               end
               default: mode <= PM_ADDR;
            endcase
         end
         if (ss_hi) mode <= PM_ADDR;
      end
   end

   // R11: the strobe never lasts two cycles
   p_strobe_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R8: continuous mode holds while the select stays low
   p_stream_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_STREAM && !ss_hi) |=> mode == PM_STREAM);

   // R7: column wrap advances the row
   p_col_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_STREAM && byte_vld && cur_col == COL_LAST)
      |=> cur_col == '0 && cur_row == $past(cur_row) + 1'b1);

   // R3: a row header loads the row and writes nothing
   p_row_hdr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_ADDR && byte_vld && byte_q[HDR_ROW_BIT])
      |=> cur_row == $past(byte_q[ROW_W-1:0]) && !wr_en);

   // R9: released select leaves the parser expecting an address
   p_release_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ss_hi |=> mode == PM_ADDR);
endmodule

// File: rtl/spi_ram_writer.sv
module spi_ram_writer #(
   parameter int DATA_W      = 8,
   parameter int ROW_W       = 4,
   parameter int COL_W       = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ss_n,
   input  logic              sck,
   input  logic              mosi,
   output logic              wr_en,
   output logic [ROW_W-1:0]  wr_row,
   output logic [COL_W-1:0]  wr_col,
   output logic [DATA_W-1:0] wr_data
);
   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("spi_ram_writer: header decode needs DATA_W of 8");
      end
      if (ROW_W < 1 || ROW_W > DATA_W - 1) begin : g_bad_row
         $error("spi_ram_writer: ROW_W must fit below the row flag bit");
      end
      if (COL_W < 1 || COL_W > DATA_W - 2) begin : g_bad_col
         $error("spi_ram_writer: COL_W must fit below the stream flag bit");
      end
   endgenerate

   logic [2:0]        pins_s;
   logic              byte_vld;
   logic [DATA_W-1:0] byte_q;

   spi_wr_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b001)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({mosi, sck, ss_n}),
      .d_sync  (pins_s)
   );

   spi_wr_shifter #(
      .DATA_W (DATA_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .ss_hi    (pins_s[0]),
      .sck_s    (pins_s[1]),
      .mosi_s   (pins_s[2]),
      .byte_vld (byte_vld),
      .byte_q   (byte_q)
   );

   spi_wr_parser #(
      .DATA_W (DATA_W),
      .ROW_W  (ROW_W),
      .COL_W  (COL_W)
   ) u_parse (
      .clk      (clk),
      .rst_n    (rst_n),
      .ss_hi    (pins_s[0]),
      .byte_vld (byte_vld),
      .byte_q   (byte_q),
      .wr_en    (wr_en),
      .wr_row   (wr_row),
      .wr_col   (wr_col),
      .wr_data  (wr_data)
   );

   // R10: with select high at the pin long enough, no write appears
   p_idle_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pins_s[0] && $past(pins_s[0])) |-> !wr_en);
endmodule

// File: tb/spi_ram_writer_test.sv
module spi_ram_writer_test;
   localparam int CLK_PERIOD = 10;
   localparam int SCK_HALF   = 4;
   localparam int WD_LIMIT   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ss_n = 1'b1;
   logic       sck = 1'b0;
   logic       mosi = 1'b0;
   logic       wr_en;
   logic [3:0] wr_row;
   logic [4:0] wr_col;
   logic [7:0] wr_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_ram_writer uut (
      .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sck(sck), .mosi(mosi),
      .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data)
   );

   int n_chk = 0;
   int n_err = 0;
   int cyc   = 0;

   logic [3:0] exp_r[$];
   logic [4:0] exp_c[$];
   logic [7:0] exp_d[$];
   string      exp_t[$];
   logic [3:0] obs_r[$];
   logic [4:0] obs_c[$];
   logic [7:0] obs_d[$];

   int         m_mode = 0;   // 0 address, 1 data, 2 continuous
   logic [3:0] m_row  = '0;
   logic [4:0] m_col  = '0;
   string      m_tag  = "R4";
   logic       prev_wr = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == WD_LIMIT) begin
         n_err++;
         $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WD_LIMIT);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   // monitor away from the active edge; R11 pulse width
   always @(negedge clk) begin
      if (rst_n && wr_en) begin
         obs_r.push_back(wr_row);
         obs_c.push_back(wr_col);
         obs_d.push_back(wr_data);
         chk(!prev_wr, "R11", "strobe width", 2, 1);
      end
      prev_wr = wr_en;
   end

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic shift_bits(input logic [7:0] b, input int nbits);
      for (int i = 7; i > 7 - nbits; i--) begin
         sck  = 1'b0;
         mosi = b[i];
         wait_clks(SCK_HALF);
         sck = 1'b1;
         wait_clks(SCK_HALF);
      end
   endtask

   task automatic begin_xfer();
      ss_n = 1'b0;
      wait_clks(3);
   endtask

   function automatic void model_byte(input logic [7:0] b);
      case (m_mode)
         0: begin
            if (b[7]) m_row = b[3:0];
            else begin
               m_col  = b[4:0];
               m_mode = b[6] ? 2 : 1;
            end
         end
         1: begin
            exp_r.push_back(m_row); exp_c.push_back(m_col);
            exp_d.push_back(b);     exp_t.push_back(m_tag);
            m_mode = 0;
         end
         default: begin
            exp_r.push_back(m_row); exp_c.push_back(m_col);
            exp_d.push_back(b);     exp_t.push_back(m_tag);
            if (m_col == 5'd31) m_row = m_row + 1'b1;
            m_col = m_col + 1'b1;
         end
      endcase
   endfunction

   task automatic put(input logic [7:0] b);
      shift_bits(b, 8);
      model_byte(b);
   endtask

   task automatic compare_all(input string cnt_tag);
      int n;
      chk(obs_r.size() == exp_r.size(), cnt_tag, "write count",
          obs_r.size(), exp_r.size());
      n = (obs_r.size() < exp_r.size()) ? obs_r.size() : exp_r.size();
      for (int i = 0; i < n; i++) begin
         chk(obs_r[i] == exp_r[i], exp_t[i], "wr_row", obs_r[i], exp_r[i]);
         chk(obs_c[i] == exp_c[i], exp_t[i], "wr_col", obs_c[i], exp_c[i]);
         chk(obs_d[i] == exp_d[i], exp_t[i], "wr_data", obs_d[i], exp_d[i]);
      end
      exp_r.delete(); exp_c.delete(); exp_d.delete(); exp_t.delete();
      obs_r.delete(); obs_c.delete(); obs_d.delete();
   endtask

   task automatic end_xfer(input string cnt_tag);
      sck = 1'b0;
      wait_clks(SCK_HALF);
      ss_n = 1'b1;
      m_mode = 0;
      wait_clks(20);
      compare_all(cnt_tag);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      wait_clks(4);
      // R1: reset state
      chk(wr_en == 1'b0, "R1", "wr_en", wr_en, 0);
      chk(wr_row == '0 && wr_col == '0, "R1", "address", {wr_row, wr_col}, 0);
      chk(wr_data == '0, "R1", "wr_data", wr_data, 0);
      rst_n = 1'b1;
      wait_clks(4);

      // R4 and R2: row, column, data; 0x01 catches bit-order errors
      begin_xfer();
      m_tag = "R4"; put(8'h82); put(8'h05); put(8'hA5);
      m_tag = "R2"; put(8'h83); put(8'h06); put(8'h01);
      end_xfer("R4");

      // R5: pair mode then back to full addressing
      begin_xfer();
      m_tag = "R5";
      put(8'h83); put(8'h01); put(8'h11); put(8'h02); put(8'h22);
      put(8'h84); put(8'h03); put(8'h33);
      end_xfer("R5");

      // R3: ignored header bits
      begin_xfer();
      m_tag = "R3"; put(8'hF6); put(8'h3A); put(8'h5C);
      end_xfer("R3");

      // R6, R7, R8: continuous mode from column 30 with wrap and a flagged byte
      begin_xfer();
      m_tag = "R6"; put(8'h89); put(8'h5E); put(8'h10); put(8'h11);
      m_tag = "R7"; put(8'h12);
      m_tag = "R8"; put(8'h92);
      m_tag = "R7"; put(8'h13);
      end_xfer("R6");

      // R9: partial byte dropped on release, parser back at address stage
      begin_xfer();
      shift_bits(8'hFF, 5);
      end_xfer("R9");
      begin_xfer();
      m_tag = "R9"; put(8'h81); put(8'h07); put(8'h77);
      end_xfer("R9");

      // R10: clocking with select high writes nothing
      for (int i = 0; i < 16; i++) begin
         mosi = i[0];
         sck = 1'b1; wait_clks(SCK_HALF);
         sck = 1'b0; wait_clks(SCK_HALF);
      end
      wait_clks(10);
      compare_all("R10");

      // random mix of formats, some ending in continuous mode
      for (int t = 0; t < 30; t++) begin
         int npairs;
         begin_xfer();
         m_tag = "R5";
         put({1'b1, 3'($urandom), 4'($urandom_range(0, 10))});
         npairs = $urandom_range(1, 4);
         for (int p = 0; p < npairs; p++) begin
            if ($urandom_range(0, 2) == 0)
               put({1'b1, 3'($urandom), 4'($urandom_range(0, 10))});
            put({2'b00, 1'($urandom), 5'($urandom)});
            put(8'($urandom));
         end
         if ($urandom_range(0, 1) == 1) begin
            m_tag = "R6";
            put({2'b01, 1'($urandom), 5'($urandom_range(24, 31))});
            for (int k = 0; k < 10; k++) put(8'($urandom));
         end
         end_xfer("R11");
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule